// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block is a watchdog whose down counter runs on its own watchdog clock, divided by four, while software programs it from a separate bus clock through a plain read/write register port. Software arms it by setting the enable bit and then feeding it with a two-write unlock sequence. Each accepted feed reloads the counter. If the counter runs out, a timeout flag is raised and, when the reset-enable bit is set, a chip-reset request is asserted and stays asserted until the block itself is reset.

Two further checks make it stricter than a plain timeout. A warning compare raises an interrupt when the count reaches a programmed value, which gives software early notice. A window compare rejects feeds that come too early, while the count is still above the window value. Configuration writes are carried into the watchdog-clock domain through a toggle handshake with a fixed latency. The running count is sampled in the watchdog domain and handed back to the bus domain through a closed-loop handshake, so a bus read never sees a torn value.

Top module: `win_watchdog`

## Requirements
- R1: After reset, the mode register (address 0) reads 0, reload (address 1) reads 0xFF, warning compare (address 4) reads 0, window (address 5) reads 0xFFFFFF and count (address 3) reads 0xFF. wd_irq and chip_rst are both 0.
- R2: A reload value below 0xFF is stored as 0xFF. Any other value is stored unchanged.
- R3: Mode bits 0 (enable), 1 (reset-enable) and 4 (protect) are set by writing 1. Writing 0 leaves them set.
- R4: Until the block is enabled and has accepted a feed, the count does not change.
- R5: An accepted feed reloads the count from the reload register. After that, the count falls by one every four watchdog-clock cycles, and the count register returns that running value.
- R6: When the count decrements onto the warning compare value, mode bit 3 and wd_irq rise 4*(reload-warning) watchdog cycles after the feed, plus the crossing latency.
- R7: Writing 1 to mode bit 3 clears the interrupt flag and wd_irq. Writing 0 to that bit leaves them set.
- R8: A decrement from 0 sets mode bit 2 (timeout flag) and reloads the count. With reset-enable clear, chip_rst stays 0.
- R9: Writing 0 to mode bit 2 clears the timeout flag. Writing 1 to that bit leaves it set.
- R10: With reset-enable set, a timeout drives chip_rst high 4*(reload+1) watchdog cycles after the feed. chip_rst then stays high until the block reset.
- R11: A feed is a write of 0xAA to address 2 immediately followed by a write of 0x55 there. Any other access in between is a feed error, which raises chip_rst when reset-enable is set.
- R12: A feed that arrives while the count is above the window value is rejected and raises chip_rst when reset-enable is set. A feed at or below the window reloads the count.
- R13: With protect set, a reload write is ignored while the count is at or above the window value, and is taken once the count is below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-port clock |
| rst_n | input | 1 | Asynchronous active-low block reset, both domains |
| wd_clk | input | 1 | Watchdog counting clock |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational on bus_addr |
| chip_rst | output | 1 | Sticky chip-reset request (watchdog domain) |
| wd_irq | output | 1 | Warning interrupt (bus domain) |

## Verification
The warning compare is swept over a grid of reload and warning pairs. The interval from the feed to wd_irq is compared against 4*(reload-warning), which separates a wrong prescale ratio or compare point from a correct one. Timeouts are run at two reload values, once with reset-enable clear and once with it set. This separates flag-only behaviour from a reset request and checks the 4*(reload+1) interval. Feeds are tried in four forms: a clean sequence, an interrupted sequence, a feed above the window and a feed inside the window. The protect bit is exercised on both sides of the window boundary.

// File: rtl/win_watchdog.sv
`timescale 1ns/1ps
module win_watchdog #(
  parameter int CNT_W      = 24,
  parameter int DATA_W     = 32,
  parameter int MIN_RELOAD = 255
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              wd_clk,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              chip_rst,
  output logic              wd_irq
);
  localparam logic [2:0] A_MODE = 3'd0, A_RELOAD = 3'd1, A_FEED = 3'd2,
                         A_COUNT = 3'd3, A_WARN = 3'd4, A_WINDOW = 3'd5;
  localparam logic [CNT_W-1:0] RMIN = CNT_W'(MIN_RELOAD);
  localparam logic [CNT_W-1:0] ONES = '1;

  // ---------------- bus domain ----------------
  logic en_b, rsten_b, prot_b, tof_b, intf_b, fseq;
  logic cfg_tog, feed_tog, ferr_tog;
  logic [CNT_W-1:0] reload_b, warn_b, win_b, cnt_b;
  logic [2:0] tof_s, int_s, snap_s;
  // watchdog-domain state referenced by the bus side
  logic tof_tog, int_tog, snap_tog, chip_rst_q;
  logic [CNT_W-1:0] hold;

  wire wr       = bus_sel & bus_we;
  wire mode_wr  = wr && bus_addr == A_MODE;
  wire feed_wr  = wr && bus_addr == A_FEED;
  wire [CNT_W-1:0] wdat = bus_wdata[CNT_W-1:0];
  wire rel_ok   = !prot_b || cnt_b < win_b;
  wire rel_wr   = wr && bus_addr == A_RELOAD && rel_ok;
  wire cfg_wr   = mode_wr || rel_wr || (wr && (bus_addr == A_WARN || bus_addr == A_WINDOW));
  wire tof_evt  = tof_s[1] ^ tof_s[2];
  wire int_evt  = int_s[1] ^ int_s[2];
  wire snap_evt = snap_s[1] ^ snap_s[2];
  logic unused_hi;
  assign unused_hi = ^bus_wdata[DATA_W-1:CNT_W];

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_b, rsten_b, prot_b, tof_b, intf_b, fseq} <= '0;
      {cfg_tog, feed_tog, ferr_tog} <= '0;
      reload_b <= RMIN; warn_b <= '0; win_b <= ONES; cnt_b <= RMIN;
      tof_s <= '0; int_s <= '0; snap_s <= '0;
    end else begin
      tof_s  <= {tof_s[1:0], tof_tog};
      int_s  <= {int_s[1:0], int_tog};
      snap_s <= {snap_s[1:0], snap_tog};
      if (snap_evt) cnt_b <= hold;
      cfg_tog <= cfg_tog ^ cfg_wr;
      if (mode_wr) begin
        en_b    <= en_b    | bus_wdata[0];
        rsten_b <= rsten_b | bus_wdata[1];
        prot_b  <= prot_b  | bus_wdata[4];
      end
      if (rel_wr) reload_b <= (wdat < RMIN) ? RMIN : wdat;
      if (wr && bus_addr == A_WARN)   warn_b <= wdat;
      if (wr && bus_addr == A_WINDOW) win_b  <= wdat;
      tof_b  <= tof_evt | (tof_b  & !(mode_wr && !bus_wdata[2]));
      intf_b <= int_evt | (intf_b & !(mode_wr &&  bus_wdata[3]));
      if (bus_sel) begin
        if (feed_wr && bus_wdata[7:0] == 8'hAA) fseq <= 1'b1;
        else if (feed_wr && bus_wdata[7:0] == 8'h55 && fseq) begin
          fseq <= 1'b0; feed_tog <= ~feed_tog;
        end else if (fseq) begin
          fseq <= 1'b0; ferr_tog <= ~ferr_tog;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:   bus_rdata = DATA_W'({prot_b, intf_b, tof_b, rsten_b, en_b});
      A_RELOAD: bus_rdata = DATA_W'(reload_b);
      A_COUNT:  bus_rdata = DATA_W'(cnt_b);
      A_WARN:   bus_rdata = DATA_W'(warn_b);
      A_WINDOW: bus_rdata = DATA_W'(win_b);
      default:  bus_rdata = '0;
    endcase
  end

  assign wd_irq = intf_b;

  // ---------------- watchdog domain ----------------
  logic [2:0] cfg_s, feed_s, ferr_s;
  logic [1:0] ack_s, presc;
  logic en_w, rsten_w, run_w;
  logic [CNT_W-1:0] reload_w, warn_w, win_w, cnt;

  wire cfg_upd  = cfg_s[1]  ^ cfg_s[2];
  wire feed_in  = feed_s[1] ^ feed_s[2];
  wire ferr_in  = ferr_s[1] ^ ferr_s[2];
  wire feed_acc = feed_in && en_w && cnt <= win_w;
  wire feed_bad = feed_in && cnt > win_w;
  wire tick     = run_w && presc == 2'd3 && !feed_acc;
  wire [CNT_W-1:0] cnt_dec = cnt - 1'b1;

  always_ff @(posedge wd_clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_s <= '0; feed_s <= '0; ferr_s <= '0; ack_s <= '0; presc <= '0;
      {en_w, rsten_w, run_w} <= '0;
      reload_w <= RMIN; warn_w <= '0; win_w <= ONES; cnt <= RMIN; hold <= RMIN;
      {tof_tog, int_tog, snap_tog, chip_rst_q} <= '0;
    end else begin
      cfg_s  <= {cfg_s[1:0],  cfg_tog};
      feed_s <= {feed_s[1:0], feed_tog};
      ferr_s <= {ferr_s[1:0], ferr_tog};
      ack_s  <= {ack_s[0], snap_s[2]};
      if (ack_s[1] == snap_tog) begin
        hold <= cnt; snap_tog <= ~snap_tog;
      end
      if (cfg_upd) begin
        en_w <= en_b; rsten_w <= rsten_b;
        reload_w <= reload_b; warn_w <= warn_b; win_w <= win_b;
      end
      if (feed_acc) begin
        cnt <= reload_w; presc <= '0; run_w <= 1'b1;
      end else if (run_w) begin
        presc <= presc + 1'b1;
        if (tick) begin
          if (cnt == '0) begin
            cnt <= reload_w; tof_tog <= ~tof_tog;
            if (rsten_w) chip_rst_q <= 1'b1;
          end else begin
            cnt <= cnt_dec;
            if (cnt_dec == warn_w) int_tog <= ~int_tog;
          end
        end
      end
      if ((ferr_in || feed_bad) && rsten_w) chip_rst_q <= 1'b1;
    end
  end

  assign chip_rst = chip_rst_q;

  // ---------------- assertions ----------------
  assert_idle_hold_R4: assert property (@(posedge wd_clk) disable iff (!rst_n)
    (!run_w && !feed_acc) |=> $stable(cnt));
  assert_count_step_R5: assert property (@(posedge wd_clk) disable iff (!rst_n)
    (tick && cnt != '0) |=> cnt == $past(cnt_dec));
  assert_underflow_reload_R8: assert property (@(posedge wd_clk) disable iff (!rst_n)
    (tick && cnt == '0) |=> (cnt == $past(reload_w) && tof_tog != $past(tof_tog)));
  assert_reset_sticky_R10: assert property (@(posedge wd_clk) disable iff (!rst_n)
    chip_rst_q |=> chip_rst_q);
  assert_window_reject_R12: assert property (@(posedge wd_clk) disable iff (!rst_n)
    (feed_in && cnt > win_w && rsten_w) |=> chip_rst_q);
  assert_set_only_R3: assert property (@(posedge bus_clk) disable iff (!rst_n)
    1'b1 |=> ((~{en_b, rsten_b, prot_b}) & $past({en_b, rsten_b, prot_b})) == 3'b000);
  assert_protect_hold_R13: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr && bus_addr == A_RELOAD && prot_b && cnt_b >= win_b) |=> $stable(reload_b));
  always @(posedge bus_clk)
    if (rst_n) assert_reload_floor_R2: assert (reload_b >= RMIN);
endmodule

// File: tb/test_win_watchdog.sv
`timescale 1ns/1ps
module test_win_watchdog;
  logic bus_clk = 0, wd_clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic chip_rst, wd_irq;
  int vectors = 0, fails = 0, wd_cnt = 0, mark = 0, start = 0;
  bit done = 0;

  always #4 bus_clk = ~bus_clk;
  always #2.5 wd_clk = ~wd_clk;
  always @(posedge wd_clk) wd_cnt++;

  win_watchdog i_win_watchdog (.bus_clk, .rst_n, .wd_clk, .bus_sel, .bus_we, .bus_addr,
    .bus_wdata, .bus_rdata, .chip_rst, .wd_irq);

  task automatic chk(input string req, input bit ok, input longint act, input longint lo, input longint hi);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic chk_eq(input string req, input longint act, input longint exp);
    chk(req, act == exp, act, exp, exp);
  endtask

  task automatic access(input logic [2:0] a, input logic [31:0] d, input bit we);
    @(negedge bus_clk); bus_sel = 1; bus_we = we; bus_addr = a; bus_wdata = d; mark = wd_cnt;
    @(posedge bus_clk); #1; bus_sel = 0; bus_we = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    access(a, d, 1'b1);
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    @(negedge bus_clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic feed();
    wr(3'd2, 32'hAA); wr(3'd2, 32'h55); start = mark;
  endtask

  task automatic blk_reset();
    rst_n = 0; repeat (3) @(negedge bus_clk); rst_n = 1; repeat (2) @(negedge bus_clk);
  endtask

  task automatic wait_wd(input int n);
    int t0 = wd_cnt;
    while (wd_cnt - t0 < n) @(negedge bus_clk);
  endtask

  task automatic arm(input int r, input int w, input int win, input int mode);
    blk_reset();
    wr(3'd4, w); wr(3'd5, win); wr(3'd1, r); wr(3'd0, mode);
    wait_wd(12);
    feed();
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      done = 1; fails++; vectors++;
      $display("FAIL watchdog expired actual=1 expected=0..0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int e, lo, hi;
    blk_reset();
    // R1 reset values
    peek(3'd0, d); chk_eq("R1 mode", d, 0);
    peek(3'd1, d); chk_eq("R1 reload", d, 'hFF);
    peek(3'd4, d); chk_eq("R1 warn", d, 0);
    peek(3'd5, d); chk_eq("R1 window", d, 'hFFFFFF);
    peek(3'd3, d); chk_eq("R1 count", d, 'hFF);
    chk_eq("R1 irq", wd_irq, 0); chk_eq("R1 chip_rst", chip_rst, 0);
    // R2 clamp
    wr(3'd1, 32'h10);     peek(3'd1, d); chk_eq("R2 clamp low", d, 'hFF);
    wr(3'd1, 32'h1234);   peek(3'd1, d); chk_eq("R2 mid", d, 'h1234);
    wr(3'd1, 32'hFFFFFF); peek(3'd1, d); chk_eq("R2 top", d, 'hFFFFFF);
    // R3 set-only bits; R4 no counting without feed
    wr(3'd0, 32'h13); wr(3'd0, 32'h00);
    peek(3'd0, d); chk_eq("R3 set-only", d & 32'h13, 'h13);
    wait_wd(400);
    peek(3'd3, d); chk_eq("R4 idle count", d, 'hFF);

    // R6 warning sweep
    for (int ri = 0; ri < 3; ri++) begin
      for (int wi = 0; wi < 3; wi++) begin
        int r = 'h100 + ri * 'h80;
        int w = wi * 'h60;
        arm(r, w, 'hFFFFFF, 'h01);
        while (!wd_irq && wd_cnt - start < 4 * (r - w) + 100) @(negedge bus_clk);
        e = wd_cnt - start; lo = 4 * (r - w) + 2; hi = 4 * (r - w) + 13;
        chk("R6 warn interval", wd_irq && e >= lo && e <= hi, e, lo, hi);
      end
    end
    // R7 interrupt flag clearing (flag set from last sweep point)
    wr(3'd0, 32'h01); chk_eq("R7 write0 keeps", wd_irq, 1);
    wr(3'd0, 32'h08); chk_eq("R7 write1 clears", wd_irq, 0);

    // R5 running count readback
    arm('h200, 0, 'hFFFFFF, 'h01);
    wait_wd(400);
    e = wd_cnt - start; peek(3'd3, d);
    lo = 'h200 - (e - 3) / 4 - 1; hi = 'h200 - (e - 20) / 4 + 1;
    chk("R5 count value", d >= lo && d <= hi, d, lo, hi);

    // R8 timeout without reset; R9 flag clearing
    for (int k = 0; k < 2; k++) begin
      int r = k ? 'h120 : 'hFF;
      arm(r, r, 'hFFFFFF, 'h01);
      d = 0;
      while (!d[2] && wd_cnt - start < 4 * (r + 1) + 100) peek(3'd0, d);
      e = wd_cnt - start; lo = 4 * (r + 1) + 2; hi = 4 * (r + 1) + 16;
      chk("R8 timeout flag interval", d[2] && e >= lo && e <= hi, e, lo, hi);
      chk_eq("R8 no chip_rst", chip_rst, 0);
      wait_wd(40); peek(3'd3, d);
      chk("R8 reloaded", d > r - 20 && d <= r, d, r - 20, r);
    end
    wr(3'd0, 32'h04); peek(3'd0, d); chk_eq("R9 write1 keeps", d[2], 1);
    wr(3'd0, 32'h00); peek(3'd0, d); chk_eq("R9 write0 clears", d[2], 0);

    // R10 timeout with reset-enable
    for (int k = 0; k < 2; k++) begin
      int r = k ? 'h140 : 'hFF;
      arm(r, r, 'hFFFFFF, 'h03);
      while (!chip_rst && wd_cnt - start < 4 * (r + 1) + 100) @(negedge bus_clk);
      e = wd_cnt - start; lo = 4 * (r + 1) + 2; hi = 4 * (r + 1) + 7;
      chk("R10 reset interval", chip_rst && e >= lo && e <= hi, e, lo, hi);
      feed(); wait_wd(4 * (r + 1) + 40);
      chk_eq("R10 sticky", chip_rst, 1);
    end
    blk_reset(); chk_eq("R10 cleared by block reset", chip_rst, 0);

    // R11 interrupted feed sequence
    for (int k = 0; k < 2; k++) begin
      arm('h200, 0, 'hFFFFFF, k ? 'h03 : 'h01);
      wait_wd(20);
      access(3'd2, 32'hAA, 1'b1); access(3'd0, 32'h0, 1'b0); access(3'd2, 32'h55, 1'b1);
      wait_wd(30);
      chk_eq(k ? "R11 error resets" : "R11 error without reset-enable", chip_rst, k);
    end

    // R12 window: early feed rejected, in-window feed accepted
    arm('h300, 0, 'h100, 'h03);
    wait_wd(20); feed(); wait_wd(30);
    chk_eq("R12 early feed resets", chip_rst, 1);
    arm('h300, 0, 'h100, 'h03);
    d = 'hFFF;
    while (d >= 'hF0 && wd_cnt - start < 4 * 'h300) peek(3'd3, d);
    feed(); wait_wd(40);
    chk_eq("R12 in-window feed no reset", chip_rst, 0);
    peek(3'd3, d); chk("R12 reloaded", d > 'h2C0 && d <= 'h300, d, 'h2C0, 'h300);

    // R13 protect
    arm('h300, 0, 'h100, 'h11);
    wait_wd(40);
    wr(3'd1, 32'h400); peek(3'd1, d); chk_eq("R13 blocked above window", d, 'h300);
    d = 'hFFF;
    while (d >= 'h100 && wd_cnt - start < 4 * 'h300) peek(3'd3, d);
    wr(3'd1, 32'h400); peek(3'd1, d); chk_eq("R13 taken below window", d, 'h400);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule